// File: doc/BRIEF.md
# Lowest Set Bit Clear Unit

This execution unit takes one source operand, clears the least significant 1 bit in it, and returns the result with a set of condition flags. It is one functional unit in an integer pipeline. The issue logic presents an operand with a one-cycle `in_valid` strobe. The unit answers one clock later with a one-cycle `out_valid` strobe that carries the result and flags, or a fault.

The active operand width depends on the execution mode. In long mode, `wide_sel` selects between 32 and 64 bits. In every other mode the width is always 32 bits and `wide_sel` has no effect. In a 32-bit operation the upper source half is ignored and the upper result half is written as zero. An encoding with the vector-length bit set raises the undefined-opcode fault. So does a request made in real or virtual-8086 mode. When the fault is raised, the architectural outputs keep their previous contents.

Control is a three-state machine: `ST_IDLE` (no output this cycle), `ST_RESULT` (a result is presented) and `ST_FAULT` (a fault is presented). From any state, a cycle with `in_valid` low moves the machine to `ST_IDLE`. A cycle with `in_valid` high and a legal request moves it to `ST_RESULT`. A cycle with `in_valid` high and an illegal request moves it to `ST_FAULT`. Reset forces `ST_IDLE`.

Top module: `lsbclr_unit`

## Requirements
- R1: For a legal request, `result` equals the active-width operand ANDed with that operand minus one, so only its lowest 1 bit is cleared.
- R2: `flag_cf` is 1 exactly when the active-width operand is zero.
- R3: `flag_zf` is 1 when `result` is zero. `flag_sf` equals result bit 63 in 64-bit operation and result bit 31 in 32-bit operation.
- R4: Each legal result drives `flag_of` to 0 and `undef_mask` to 2'b11, where bit 0 marks the auxiliary-carry flag and bit 1 marks the parity flag as undefined.
- R5: The width is 64 bits only when `long_mode`=1 and `wide_sel`=1. In every other case it is 32 bits, and `wide_sel` is ignored when `long_mode`=0.
- R6: In 32-bit operation, source bits 63:32 have no effect and result bits 63:32 are 0.
- R7: A request with `vlen`=1 raises `fault`.
- R8: A request with `legacy_mode`=1 raises `fault`.
- R9: On a fault, `out_valid` and `fault` are both high for that cycle. `result`, all flags and `undef_mask` keep the values they had before the request.
- R10: Outputs appear in the cycle after the `in_valid` edge. `out_valid` is high for one cycle per request and low when there is no request.
- R11: Synchronous active-high `rst` clears `out_valid`, `fault`, `result`, all flags and `undef_mask`.
- R12: A zero operand gives `result`=0, `flag_zf`=1, `flag_sf`=0 and `flag_cf`=1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle request strobe |
| src | input | 64 | Source operand |
| long_mode | input | 1 | 1 when the core runs in 64-bit mode |
| wide_sel | input | 1 | Width select, 1 = 64-bit, honoured only in long mode |
| vlen | input | 1 | Vector-length bit of the encoding, must be 0 |
| legacy_mode | input | 1 | 1 in real or virtual-8086 mode |
| out_valid | output | 1 | One-cycle response strobe |
| result | output | 64 | Operand with its lowest set bit cleared |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_cf | output | 1 | Carry flag, set for a zero operand |
| flag_of | output | 1 | Overflow flag, always cleared |
| undef_mask | output | 2 | Undefined-flag mask (bit 0 AF, bit 1 PF) |
| fault | output | 1 | Undefined-opcode fault strobe |

## Verification
A wrong state in the control machine shows up in the very next cycle. The symptoms are a missing or stretched `out_valid`, or `fault` asserted alongside an ordinary result. Wrong output registers cause different symptoms. If a faulting request writes them, the next fault exposes it, because the held values no longer match the previous good result. A wrong width decode affects only bit 31 or bit 63 and the upper result half, so the checks rely on operands whose upper and lower halves differ.

// File: rtl/lsbclr_pkg.sv
package lsbclr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } lsbclr_state_t;

    typedef struct packed {
        logic sf;
        logic zf;
        logic cf;
        logic of;
    } lsbclr_flags_t;

    localparam int UNDEF_W      = 2;
    localparam int UNDEF_AF_BIT = 0;
    localparam int UNDEF_PF_BIT = 1;

endpackage

// File: rtl/lsbclr_mode_dec.sv
module lsbclr_mode_dec (
    input  logic long_mode,
    input  logic wide_sel,
    input  logic vlen,
    input  logic legacy_mode,
    output logic use_wide,
    output logic illegal
);
    // Width select is honoured only in long mode
    assign use_wide = long_mode & wide_sel;
    // Vector-length bit set, or real/virtual-8086 mode, is an undefined opcode
    assign illegal  = vlen | legacy_mode;
endmodule

// File: rtl/lsbclr_core.sv
module lsbclr_core
    import lsbclr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic              use_wide,
    output logic [DATA_W-1:0] res,
    output lsbclr_flags_t     flags
);
    localparam int UPPER_W = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] opnd_m1;

    always_comb begin
        opnd    = use_wide ? src : (src & NARROW_MASK);
        opnd_m1 = opnd - {{(DATA_W-1){1'b0}}, 1'b1};
        res     = opnd & opnd_m1;
        flags.sf = use_wide ? res[DATA_W-1] : res[NARROW_W-1];
        flags.zf = (res == '0);
        flags.cf = (opnd == '0);
        flags.of = 1'b0;
    end
endmodule

// File: rtl/lsbclr_unit.sv
module lsbclr_unit
    import lsbclr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  src,
    input  logic               long_mode,
    input  logic               wide_sel,
    input  logic               vlen,
    input  logic               legacy_mode,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               flag_sf,
    output logic               flag_zf,
    output logic               flag_cf,
    output logic               flag_of,
    output logic [UNDEF_W-1:0] undef_mask,
    output logic               fault
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    lsbclr_state_t     state_q, state_d;
    logic              dec_wide, dec_illegal;
    logic [DATA_W-1:0] core_res;
    lsbclr_flags_t     core_flags;
    logic [DATA_W-1:0] result_q;
    lsbclr_flags_t     flags_q;
    logic [UNDEF_W-1:0] undef_q;

    lsbclr_mode_dec u_dec (
        .long_mode   (long_mode),
        .wide_sel    (wide_sel),
        .vlen        (vlen),
        .legacy_mode (legacy_mode),
        .use_wide    (dec_wide),
        .illegal     (dec_illegal)
    );

    lsbclr_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
        .src      (src),
        .use_wide (dec_wide),
        .res      (core_res),
        .flags    (core_flags)
    );

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (in_valid)
                    state_d = dec_illegal ? ST_FAULT : ST_RESULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output registers: written only by a legal request
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
            undef_q  <= '0;
        end else if (in_valid && !dec_illegal) begin
            result_q <= core_res;
            flags_q  <= core_flags;
            undef_q  <= '0;
            undef_q[UNDEF_AF_BIT] <= 1'b1;
            undef_q[UNDEF_PF_BIT] <= 1'b1;
        end
    end

    assign out_valid  = (state_q != ST_IDLE);
    assign fault      = (state_q == ST_FAULT);
    assign result     = result_q;
    assign flag_sf    = flags_q.sf;
    assign flag_zf    = flags_q.zf;
    assign flag_cf    = flags_q.cf;
    assign flag_of    = flags_q.of;
    assign undef_mask = undef_q;

    AST_RESULT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_illegal) |=> ((result & ~$past(src)) == '0)); // R1

    AST_CARRY_IMPLIES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !fault && flag_cf) |-> (flag_zf && !flag_sf && result == '0)); // R12

    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_illegal && !(long_mode && wide_sel)) |=> (result[DATA_W-1:NARROW_W] == {UPPER_W{1'b0}})); // R6

    AST_FAULT_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec_illegal) |=> ($stable(result) && $stable(flag_zf) && $stable(flag_cf) && $stable(undef_mask))); // R9

    AST_VALID_FOLLOWS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R10

    AST_ILLEGAL_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (vlen || legacy_mode)) |=> (fault && out_valid)); // R7

    AST_OF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_illegal) |=> (!flag_of && undef_mask == 2'b11)); // R4

endmodule

// File: tb/test_lsbclr_unit.sv
`timescale 1ns/1ps
module test_lsbclr_unit;

    typedef struct {
        logic        flt;
        logic [63:0] res;
        logic        sf, zf, cf, of;
        logic [1:0]  mask;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic        long_mode = 1'b0, wide_sel = 1'b0, vlen = 1'b0, legacy_mode = 1'b0;
    logic        out_valid, flag_sf, flag_zf, flag_cf, flag_of, fault;
    logic [63:0] result;
    logic [1:0]  undef_mask;

    int n_vec = 0;
    int n_bad = 0;
    exp_t q[$];
    logic exp_ov = 1'b0;

    logic [63:0] h_res  = '0;
    logic        h_sf = 0, h_zf = 0, h_cf = 0, h_of = 0;
    logic [1:0]  h_mask = '0;

    always #10 clk = ~clk;

    lsbclr_unit i_lsbclr_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .long_mode(long_mode), .wide_sel(wide_sel), .vlen(vlen), .legacy_mode(legacy_mode),
        .out_valid(out_valid), .result(result), .flag_sf(flag_sf), .flag_zf(flag_zf),
        .flag_cf(flag_cf), .flag_of(flag_of), .undef_mask(undef_mask), .fault(fault)
    );

    // R10: out_valid expected exactly one cycle after each request
    always @(posedge clk) exp_ov <= rst ? 1'b0 : in_valid;

    task automatic send(input logic [63:0] s, input logic lm, input logic ws,
                        input logic vl, input logic lg, input string tag);
        exp_t e;
        logic        wide;
        logic [63:0] op;
        @(negedge clk);
        src = s; long_mode = lm; wide_sel = ws; vlen = vl; legacy_mode = lg;
        in_valid = 1'b1;
        e.tag = tag;
        if (vl || lg) begin                      // R7 R8 R9
            e.flt = 1'b1;
            e.res = h_res; e.sf = h_sf; e.zf = h_zf; e.cf = h_cf; e.of = h_of; e.mask = h_mask;
        end else begin
            wide = lm & ws;                      // R5
            op   = wide ? s : {32'h0, s[31:0]};  // R6
            e.flt = 1'b0;
            e.res = op & (op - 64'd1);           // R1
            e.sf  = wide ? e.res[63] : e.res[31];// R3
            e.zf  = (e.res == 64'd0);
            e.cf  = (op == 64'd0);               // R2
            e.of  = 1'b0;                        // R4
            e.mask = 2'b11;
            h_res = e.res; h_sf = e.sf; h_zf = e.zf; h_cf = e.cf; h_of = e.of; h_mask = e.mask;
        end
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            n_vec++;
            if (out_valid !== exp_ov) begin
                n_bad++;
                $display("FAIL R10: out_valid=%0b expected %0b", out_valid, exp_ov);
            end
            if (out_valid === 1'b1) begin
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10: unexpected output, got 1 expected 0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    n_vec++;
                    if (fault !== e.flt || result !== e.res || flag_sf !== e.sf ||
                        flag_zf !== e.zf || flag_cf !== e.cf || flag_of !== e.of ||
                        undef_mask !== e.mask) begin
                        n_bad++;
                        $display("FAIL %s: flt=%0b res=%h sf%0b zf%0b cf%0b of%0b m%b expected flt=%0b res=%h sf%0b zf%0b cf%0b of%0b m%b",
                                 e.tag, fault, result, flag_sf, flag_zf, flag_cf, flag_of, undef_mask,
                                 e.flt, e.res, e.sf, e.zf, e.cf, e.of, e.mask);
                    end
                end
            end
        end
    end

    task automatic check_reset(input string tag);
        n_vec++;
        if (out_valid !== 1'b0 || fault !== 1'b0 || result !== 64'd0 || flag_sf !== 1'b0 ||
            flag_zf !== 1'b0 || flag_cf !== 1'b0 || flag_of !== 1'b0 || undef_mask !== 2'b00) begin
            n_bad++;
            $display("FAIL %s: ov%0b flt%0b res=%h flags=%0b%0b%0b%0b m%b expected all zero",
                     tag, out_valid, fault, result, flag_sf, flag_zf, flag_cf, flag_of, undef_mask);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R11 initial");
        rst = 1'b0;

        send(64'h8000_0000_0000_0000, 1, 1, 0, 0, "R1 R3 wide msb");
        send(64'h0000_0000_0000_00F0, 1, 1, 0, 0, "R1 wide low");
        send(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0, "R3 wide all ones sf");
        send(64'h0000_0000_0000_0000, 1, 1, 0, 0, "R12 wide zero");
        send(64'h1234_0000_0000_0000, 1, 0, 0, 0, "R2 R6 narrow upper ignored");
        send(64'hABCD_0000_8000_0001, 1, 0, 0, 0, "R6 narrow sf bit31");
        send(64'hABCD_0000_C000_0000, 0, 1, 0, 0, "R5 wide_sel ignored");
        send(64'h0000_0000_0000_0001, 0, 0, 0, 0, "R1 single bit");
        idle();
        send(64'h0000_0000_0000_0003, 1, 1, 0, 0, "R4 before fault");
        send(64'h0000_0000_0000_00FF, 1, 1, 1, 0, "R7 vlen fault");
        send(64'h0000_0000_0000_00FF, 0, 0, 0, 1, "R8 legacy fault");
        idle();
        send(64'h0000_0000_0000_0000, 0, 0, 0, 0, "R12 narrow zero");
        send(64'h5555_5555_0000_0000, 1, 1, 1, 1, "R9 fault holds zero flags");
        send(64'hF000_0000_0000_0000, 1, 1, 0, 0, "R3 after fault");
        for (int i = 0; i < 64; i++)
            send(64'd1 << i | (64'd1 << 63), 1, 1, 0, 0, "R1 sweep");
        for (int i = 0; i < 40; i++)
            send({32'hDEAD_BEEF, 32'h1 << (i % 32)}, i[0], 0, 0, 0, "R6 R2 narrow sweep");
        idle();
        idle();
        n_vec++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d results missing expected 0", q.size());
        end
        send(64'h0000_0000_0000_0006, 1, 1, 0, 0, "R11 before reset");
        idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset("R11 mid-run");
        h_res = '0; h_sf = 0; h_zf = 0; h_cf = 0; h_of = 0; h_mask = '0;
        rst = 1'b0;
        send(64'h0000_0000_0000_0010, 1, 1, 1, 0, "R9 fault after reset");
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule